// File: doc/BRIEF.md
# Byte-Lane Static RAM Functional Model

This block is a synthesizable, clocked stand-in for a word-organized asynchronous static RAM with two byte lanes per word. All control pins are active low: a chip select, an output enable, a write strobe and one enable per byte lane. The pins are registered on a fast sampling clock, and the model then applies the device truth table: reads drive only the enabled lanes, writes update only the enabled lanes, and every lane not driving read data reports high impedance.

The bidirectional data bus is split into a write-data input, a read-data output and one drive flag per lane, so a surrounding bench or pad wrapper can build the tri-state bus from them. A write is held open while its condition stays true and is committed to the array once that condition goes away, whether the write strobe, the chip select or the lane enable ended it. Depth is a parameter, so the full 18-bit address space can be cut down to a small array for simulation. In that case the upper address bits are ignored.

Top module: `sram_lane_model`

## Requirements
- R1: After reset both drive flags are 0 and the read-data output is all zeros.
- R2: Lane 0 (enable bit 0) owns data bits 7:0, and lane 1 (enable bit 1) owns data bits 15:8.
- R3: While chip select is high, no lane drives and no lane is written, whatever the other pins do.
- R4: With chip select and output enable low and write strobe high, each lane whose enable is low drives its stored byte. Every other lane has its drive flag at 0 and reads as zero.
- R5: With chip select and write strobe low, each enabled lane is written even if output enable is low, and no lane drives.
- R6: With both lane enables high, nothing drives and nothing is written.
- R7: With chip select low and both output enable and write strobe high, no lane drives.
- R8: A write stores the address and data from its last sample inside the write condition. The new data is visible to reads two clock edges after the pins leave that condition, whichever pin ended it.
- R9: A lane that is not enabled during a write keeps its stored byte.
- R10: Only the low DEPTH_LOG2 address bits select a word, so addresses that differ only above them hit the same word.
- R11: Outputs follow the pins with one sampling edge of latency: a change made between edges shows on the outputs just after the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Data presented for writes |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| lane_n_i | input | LANES | Byte-lane enables, active low, bit 0 = low byte |
| rdata_o | output | LANES*LANE_W | Read data, zero in lanes not driving |
| drive_o | output | LANES | Per-lane drive flag, 1 = lane drives the bus |

## Verification
The hardest case to reach from the ports is the commit edge of a write. The array cannot be read while a write is still open, so whether the stored value comes from the last active sample can only be seen after the write has closed. The stimulus changes the write data on every cycle of one write, then closes writes in three ways (lane enable, chip select and write strobe) and reads back. In the last case it switches straight from writing to reading the same word, so the read data is checked on the edge before the commit and on the edge after it.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  // a lane drives read data on the bus
  function automatic logic lane_reads(input logic cs_n, input logic oe_n,
                                      input logic we_n, input logic lane_n);
    return !cs_n && !oe_n && we_n && !lane_n;
  endfunction

  // a lane is inside an open write
  function automatic logic lane_writes(input logic cs_n, input logic we_n,
                                       input logic lane_n);
    return !cs_n && !we_n && !lane_n;
  endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [LANES-1:0]  lane_n_i,
  output logic [IDX_W-1:0]  s_idx,
  output logic [DATA_W-1:0] s_wdata,
  output logic              s_cs_n,
  output logic              s_oe_n,
  output logic              s_we_n,
  output logic [LANES-1:0]  s_lane_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_idx    <= '0;
      s_wdata  <= '0;
      s_cs_n   <= 1'b1;
      s_oe_n   <= 1'b1;
      s_we_n   <= 1'b1;
      s_lane_n <= '1;
    end else begin
      s_idx    <= idx_i;
      s_wdata  <= wdata_i;
      s_cs_n   <= cs_n_i;
      s_oe_n   <= oe_n_i;
      s_we_n   <= we_n_i;
      s_lane_n <= lane_n_i;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_cs_n,
  input  logic             s_oe_n,
  input  logic             s_we_n,
  input  logic [LANES-1:0] s_lane_n,
  output logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] wr_open,
  output logic [LANES-1:0] commit
);

  logic [LANES-1:0] was_open;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_en[l]   = lane_reads(s_cs_n, s_oe_n, s_we_n, s_lane_n[l]);
    assign wr_open[l] = lane_writes(s_cs_n, s_we_n, s_lane_n[l]);
    // commit fires on the first sample outside an open write
    assign commit[l]  = was_open[l] && !wr_open[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_open[l] <= 1'b0;
      else        was_open[l] <= wr_open[l];
    end

    // R8: one write window gives exactly one commit
    assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      commit[l] |=> !commit[l]);

    // R5: a lane never drives read data while its write is open
    assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_open[l] |-> !rd_en[l]);
  end

endmodule

// File: rtl/sram_byte_bank.sv
module sram_byte_bank #(
  parameter int IDX_W  = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              commit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte
);

  localparam int WORDS = 1 << IDX_W;

  logic [LANE_W-1:0] cells [WORDS];
  logic [IDX_W-1:0]  hold_idx;
  logic [LANE_W-1:0] hold_byte;

  // remember the last sample taken inside the write window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_idx  <= '0;
      hold_byte <= '0;
    end else if (capture) begin
      hold_idx  <= idx;
      hold_byte <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) cells[hold_idx] <= hold_byte;
  end

  assign rbyte = cells[idx];

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model #(
  parameter int ADDR_W     = 18,
  parameter int DEPTH_LOG2 = 6,
  parameter int LANE_W     = 8,
  parameter int LANES      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    cs_n_i,
  input  logic                    oe_n_i,
  input  logic                    we_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic [LANES-1:0]        drive_o
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = DEPTH_LOG2;

  // word select keeps only the low address bits
  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0]  s_idx;
  logic [DATA_W-1:0] s_wdata;
  logic              s_cs_n, s_oe_n, s_we_n;
  logic [LANES-1:0]  s_lane_n;
  logic [LANES-1:0]  rd_en, wr_open, commit;

  sram_pin_sampler #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LANES(LANES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_i    (word_index(addr_i)),
    .wdata_i  (wdata_i),
    .cs_n_i   (cs_n_i),
    .oe_n_i   (oe_n_i),
    .we_n_i   (we_n_i),
    .lane_n_i (lane_n_i),
    .s_idx    (s_idx),
    .s_wdata  (s_wdata),
    .s_cs_n   (s_cs_n),
    .s_oe_n   (s_oe_n),
    .s_we_n   (s_we_n),
    .s_lane_n (s_lane_n)
  );

  sram_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_cs_n   (s_cs_n),
    .s_oe_n   (s_oe_n),
    .s_we_n   (s_we_n),
    .s_lane_n (s_lane_n),
    .rd_en    (rd_en),
    .wr_open  (wr_open),
    .commit   (commit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] q;

    sram_byte_bank #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (wr_open[l]),
      .commit  (commit[l]),
      .idx     (s_idx),
      .wbyte   (s_wdata[l*LANE_W +: LANE_W]),
      .rbyte   (q)
    );

    assign rdata_o[l*LANE_W +: LANE_W] = rd_en[l] ? q : '0;
  end

  assign drive_o = rd_en;

  // R3: a deselected sample leaves every lane undriven
  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i) |-> drive_o == '0);

  // R5: write strobe outranks output enable at the pins
  assert_write_beats_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_n_i && !we_n_i) |-> drive_o == '0);

  // R4: a lane whose enable was high never drives
  assert_lane_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o & $past(lane_n_i)) == '0);

  // R7: idle selected state drives nothing
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n_i && we_n_i) |-> drive_o == '0);

endmodule

// File: tb/sram_lane_model_bench.sv
module sram_lane_model_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic [15:0] rdata;
  logic [1:0]  drive;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sram_lane_model u_sram_lane_model (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .cs_n_i(cs_n), .oe_n_i(oe_n), .we_n_i(we_n), .lane_n_i(lane_n),
    .rdata_o(rdata), .drive_o(drive)
  );

  typedef struct packed {
    logic        cs_n, oe_n, we_n;
    logic [1:0]  lane_n;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic [1:0]  exp_drv;
    logic [15:0] exp_dat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 2'b00, 18'd5,  16'hFFFF, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 18'd5,  16'hA1B2, 2'b00, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 18'd9,  16'h5555, 2'b00, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 18'd5,  16'h0000, 2'b11, 16'hA1B2},
    '{1'b0, 1'b0, 1'b1, 2'b10, 18'd5,  16'h0000, 2'b01, 16'h00B2},
    '{1'b0, 1'b0, 1'b1, 2'b01, 18'd5,  16'h0000, 2'b10, 16'hA100},
    '{1'b0, 1'b0, 1'b0, 2'b10, 18'd5,  16'h1234, 2'b00, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 18'd5,  16'h0000, 2'b11, 16'hA134},
    '{1'b0, 1'b1, 1'b0, 2'b11, 18'd9,  16'hDEAD, 2'b00, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 18'd9,  16'h0000, 2'b11, 16'h5555},
    '{1'b0, 1'b1, 1'b1, 2'b00, 18'd5,  16'h0000, 2'b00, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 18'd69, 16'h0000, 2'b11, 16'hA134},
    '{1'b1, 1'b1, 1'b0, 2'b00, 18'd5,  16'h0000, 2'b00, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b00, 18'd5,  16'h0000, 2'b11, 16'hA134}
  };
  localparam string TAG [NV] = '{
    "R3 deselect", "R5 write", "R5 write", "R4 read", "R2 low lane",
    "R2 high lane", "R5 write oe low", "R9 kept lane", "R6 no lanes",
    "R6 nothing written", "R7 idle", "R10 alias", "R3 no write",
    "R3 data kept"
  };

  task automatic check(input string tag, input logic [15:0] got,
                       input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pins(input logic c, input logic o, input logic w,
                      input logic [1:0] ln, input logic [17:0] a,
                      input logic [15:0] d);
    cs_n = c; oe_n = o; we_n = w; lane_n = ln; addr = a; wdata = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 drive after reset", {14'd0, drive}, 16'h0000);
    check("R1 data after reset", rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      pins(VEC[i].cs_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].lane_n,
           VEC[i].addr, VEC[i].wdata);
      tick(3);
      check({TAG[i], " drive"}, {14'd0, drive}, {14'd0, VEC[i].exp_drv});
      check({TAG[i], " data"}, rdata, VEC[i].exp_dat);
      pins(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0000);
      tick(3);
    end

    // R11: one edge of latency from pins to outputs
    pins(1'b0, 1'b0, 1'b1, 2'b00, 18'd5, 16'h0000);
    #1;
    check("R11 before edge", {14'd0, drive}, 16'h0000);
    tick(1);
    check("R11 after edge", {14'd0, drive}, 16'h0003);
    pins(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0000);
    tick(3);

    // R8: last sample wins, write closed by the lane enables
    pins(1'b0, 1'b1, 1'b0, 2'b00, 18'd20, 16'h1111); tick(1);
    wdata = 16'h2222; tick(1);
    wdata = 16'h3333; tick(1);
    lane_n = 2'b11; tick(3);
    pins(1'b0, 1'b0, 1'b1, 2'b00, 18'd20, 16'h0000); tick(3);
    check("R8 last sample, lane close", rdata, 16'h3333);

    // R8: write closed by chip select
    pins(1'b0, 1'b1, 1'b0, 2'b00, 18'd21, 16'h4444); tick(2);
    cs_n = 1'b1; tick(3);
    pins(1'b0, 1'b0, 1'b1, 2'b00, 18'd21, 16'h0000); tick(3);
    check("R8 chip select close", rdata, 16'h4444);

    // R8: commit lands two edges after the write strobe closes
    pins(1'b0, 1'b1, 1'b0, 2'b00, 18'd22, 16'h0000); tick(2);
    pins(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0000); tick(3);
    pins(1'b0, 1'b0, 1'b0, 2'b00, 18'd22, 16'h7777); tick(3);
    we_n = 1'b1; tick(1);
    check("R8 before commit", rdata, 16'h0000);
    tick(1);
    check("R8 after commit", rdata, 16'h7777);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule